// File: doc/BRIEF.md
# Write-Through Invalidating Snoop Cache Controller

This block controls a small direct-mapped cache that holds one data word per line and writes through to memory. It sits between a processor request port and a shared atomic bus. Each line has one state bit: valid or invalid. A processor read that finds a valid line with a matching tag is answered from the cache and uses no bus cycle. A read that misses wins the bus, fetches the word and fills the line. Every processor write goes to the bus. A write that hits also updates the cached word. A write that misses leaves the cache untouched.

The controller watches a snoop port that mirrors every bus transaction. When another requester writes an address that this cache holds valid, the matching line drops to invalid. The next local read of that address then misses and fetches the fresh value. Each bus transaction carries the requester's ID. A snooped write that bears this cache's own ID is therefore ignored.

The controller is a four-state machine with these states:
- IDLE accepts a request.
- ARB asks for the bus and waits for the grant.
- XFER drives the command and waits for the acknowledge.
- DONE pulses completion to the processor for one cycle.

The transitions are:
- IDLE→DONE on a read hit.
- IDLE→ARB on a read miss or on any write.
- ARB→XFER when the grant is seen.
- XFER→DONE when the acknowledge is seen.
- DONE→IDLE always.

Top module: `wtinv_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_done`, `bus_req` and `bus_valid` are 0, and the state is IDLE.
- R2: A read accepted in IDLE whose line is valid with a matching tag raises `cpu_done` in the next cycle. `cpu_rdata` then holds the cached word, and `bus_req` stays 0 for the whole operation.
- R3: A read that misses raises `bus_req` in the cycle after acceptance. After the grant it drives `bus_valid=1` with `bus_wr=0`, the request address and `bus_id` equal to the local ID. On `bus_ack` it returns `bus_rdata` on `cpu_rdata` and fills the line as valid.
- R4: Every write, hit or miss, performs a bus transaction with `bus_wr=1`, the request address and the write data. A write hit replaces the cached word and keeps the line valid. A write miss allocates nothing.
- R5: While waiting for `bus_gnt`, the controller keeps `bus_req` high and `bus_valid` low, and the cache contents do not change for the request. `bus_valid` first rises only in the cycle after a sampled grant.
- R6: `cpu_done` is high for exactly one cycle, in the cycle after `bus_ack` is sampled in XFER. It is never high together with `bus_valid`. `bus_req` falls with completion. `cpu_req` is only sampled in IDLE.
- R7: A snooped write (`snp_valid=1`, `snp_wr=1`) whose `snp_id` differs from the local ID and whose address matches a valid line invalidates that line at the next edge. The next local read of that address misses and returns the new memory value.
- R8: A snooped write carrying the local ID leaves the line valid.
- R9: Two kinds of snoop leave the line valid: a snooped read (`snp_wr=0`), and a snooped write whose tag differs from the held one.
- R10: For 32-bit addresses and 16 lines, bits [1:0] are the byte offset, bits [5:2] select the line and bits [31:6] are the tag. A read of a different tag at the same index replaces the line, so the earlier address then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, sampled in IDLE |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read result, valid while cpu_done |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request, held until completion |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | Bus command valid |
| bus_wr | output | 1 | Bus command: 1 = write, 0 = read |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_id | output | 2 | Requester ID of this cache |
| bus_rdata | input | 32 | Bus read data, taken with bus_ack |
| bus_ack | input | 1 | Bus transaction completion |
| snp_valid | input | 1 | Observed bus transaction present |
| snp_wr | input | 1 | Observed transaction is a write |
| snp_addr | input | 32 | Observed transaction address |
| snp_id | input | 2 | Observed transaction requester ID |

## Verification
A read hit completes one edge after acceptance, so the bench drives the request at a falling edge and expects `cpu_done` at the next falling edge. A miss or a write shows `bus_req` at that same point. `bus_valid` appears one edge after the grant, and `cpu_done` one edge after the acknowledge. The bench samples each result at exactly that falling edge and checks one falling edge later that the pulse has ended. A snoop invalidation takes effect at the edge that samples it, so the bench issues the following read only after that edge. The bench predicts hit or miss and the returned word from its own model of line tags and memory contents. It checks every index across the sweep.

// File: rtl/wtinv_pkg.sv
package wtinv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARB  = 2'd1,
        ST_XFER = 2'd2,
        ST_DONE = 2'd3
    } ctl_state_t;

endpackage

// File: rtl/wtinv_line_store.sv
module wtinv_line_store #(
    parameter int LINES  = 16,
    parameter int TAG_W  = 26,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // lookup port for the processor side
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    // probe port for the snoop side
    input  logic [IDX_W-1:0]  pr_idx,
    output logic              pr_valid,
    output logic [TAG_W-1:0]  pr_tag,
    // update port
    input  logic              wr_en,
    input  logic              wr_fill,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [IDX_W-1:0]  inv_idx
);

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    assign lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    assign lk_data  = data_q[lk_idx];
    assign pr_valid = valid_q[pr_idx];
    assign pr_tag   = tag_q[pr_idx];

    // Invalidate first; a fill on the same edge wins (cannot coincide on an atomic bus).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (inv_en)
                valid_q[inv_idx] <= 1'b0;
            if (wr_en && wr_fill)
                valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_idx] <= wr_data;
            if (wr_fill)
                tag_q[wr_idx] <= wr_tag;
        end
    end

    // R7: an invalidation not overridden by a fill leaves the line invalid
    a_r7_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(wr_en && wr_fill && wr_idx == inv_idx)) |=> !valid_q[$past(inv_idx)]);

    // R1: all lines invalid right after reset
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0));

endmodule

// File: rtl/wtinv_snoop_filter.sv
module wtinv_snoop_filter #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 2,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 2,
    parameter logic [ID_W-1:0] LOCAL_ID = '0,
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              snp_valid,
    input  logic              snp_wr,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id,
    output logic [IDX_W-1:0]  pr_idx,
    input  logic              pr_valid,
    input  logic [TAG_W-1:0]  pr_tag,
    output logic              inv_en
);

    logic             foreign_wr;
    logic [TAG_W-1:0] snp_tag;

    assign pr_idx     = snp_addr[OFF_W +: IDX_W];
    assign snp_tag    = snp_addr[ADDR_W-1 -: TAG_W];
    assign foreign_wr = snp_valid && snp_wr && (snp_id != LOCAL_ID);
    assign inv_en     = foreign_wr && pr_valid && (pr_tag == snp_tag);

endmodule

// File: rtl/wtinv_ctl_fsm.sv
module wtinv_ctl_fsm
    import wtinv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       lk_hit,
    input  logic       bus_gnt,
    input  logic       bus_ack,
    output ctl_state_t state,
    output logic       accept,
    output logic       commit,
    output logic       bus_req,
    output logic       bus_valid,
    output logic       cpu_done
);

    ctl_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cpu_req) state_d = (!cpu_we && lk_hit) ? ST_DONE : ST_ARB;
            ST_ARB:  if (bus_gnt) state_d = ST_XFER;
            ST_XFER: if (bus_ack) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept    = (state_q == ST_IDLE) && cpu_req;
        commit    = (state_q == ST_XFER) && bus_ack;
        bus_req   = (state_q == ST_ARB) || (state_q == ST_XFER);
        bus_valid = (state_q == ST_XFER);
        cpu_done  = (state_q == ST_DONE);
    end

    assign state = state_q;

    // R5: a command only follows a sampled grant
    a_r5_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_valid) |-> $past(bus_gnt));

    // R6: completion and a live bus command never overlap
    a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && cpu_done));

    // R6: completion lasts one cycle
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

endmodule

// File: rtl/wtinv_cache_ctrl.sv
module wtinv_cache_ctrl
    import wtinv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int ID_W   = 2,
    parameter logic [ID_W-1:0] LOCAL_ID = 2'd1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_valid,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [ID_W-1:0]   bus_id,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              snp_valid,
    input  logic              snp_wr,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ID_W-1:0]   snp_id
);

    localparam int IDX_W = $clog2(LINES);
    localparam int OFF_W = $clog2(DATA_W / 8);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    ctl_state_t        state;
    logic              accept, commit;
    logic              rq_we;
    logic [ADDR_W-1:0] rq_addr;
    logic [DATA_W-1:0] rq_wdata;
    logic [DATA_W-1:0] rdata_q;

    logic [ADDR_W-1:0] lk_addr;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic [IDX_W-1:0]  pr_idx;
    logic              pr_valid;
    logic [TAG_W-1:0]  pr_tag;
    logic              inv_en;
    logic              wr_en;

    // In IDLE the lookup serves the incoming request, otherwise the held one.
    assign lk_addr = (state == ST_IDLE) ? cpu_addr : rq_addr;

    wtinv_ctl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .lk_hit    (lk_hit),
        .bus_gnt   (bus_gnt),
        .bus_ack   (bus_ack),
        .state     (state),
        .accept    (accept),
        .commit    (commit),
        .bus_req   (bus_req),
        .bus_valid (bus_valid),
        .cpu_done  (cpu_done)
    );

    // Reads always fill on completion; writes touch the line only if it is still a hit.
    assign wr_en = commit && (!rq_we || lk_hit);

    wtinv_line_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_addr[OFF_W +: IDX_W]),
        .lk_tag   (lk_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .pr_idx   (pr_idx),
        .pr_valid (pr_valid),
        .pr_tag   (pr_tag),
        .wr_en    (wr_en),
        .wr_fill  (!rq_we),
        .wr_idx   (rq_addr[OFF_W +: IDX_W]),
        .wr_tag   (rq_addr[ADDR_W-1 -: TAG_W]),
        .wr_data  (rq_we ? rq_wdata : bus_rdata),
        .inv_en   (inv_en),
        .inv_idx  (pr_idx)
    );

    wtinv_snoop_filter #(
        .ADDR_W   (ADDR_W),
        .ID_W     (ID_W),
        .IDX_W    (IDX_W),
        .OFF_W    (OFF_W),
        .LOCAL_ID (LOCAL_ID)
    ) u_snoop (
        .snp_valid (snp_valid),
        .snp_wr    (snp_wr),
        .snp_addr  (snp_addr),
        .snp_id    (snp_id),
        .pr_idx    (pr_idx),
        .pr_valid  (pr_valid),
        .pr_tag    (pr_tag),
        .inv_en    (inv_en)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_we    <= 1'b0;
            rq_addr  <= '0;
            rq_wdata <= '0;
            rdata_q  <= '0;
        end else begin
            if (accept) begin
                rq_we    <= cpu_we;
                rq_addr  <= cpu_addr;
                rq_wdata <= cpu_wdata;
                if (!cpu_we && lk_hit)
                    rdata_q <= lk_data;
            end
            if (commit && !rq_we)
                rdata_q <= bus_rdata;
        end
    end

    assign cpu_rdata = rdata_q;
    assign bus_wr    = rq_we;
    assign bus_addr  = rq_addr;
    assign bus_wdata = rq_wdata;
    assign bus_id    = LOCAL_ID;

    // R2: a read hit completes next cycle without the bus
    a_r2_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_we && lk_hit) |=> (cpu_done && !bus_req));

    // R4: every write asks for the bus
    a_r4_write_to_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_we) |=> (bus_req && !cpu_done));

    // R6: completion follows the acknowledge by one cycle
    a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ack) |=> (cpu_done && !bus_req));

    // R5: holding for the grant keeps the request up
    a_r5_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_valid && !bus_gnt) |=> (bus_req && !bus_valid));

endmodule

// File: tb/tb_wtinv_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wtinv_cache_ctrl;

    localparam logic [1:0] MY_ID = 2'd1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_done, bus_req, bus_valid, bus_wr;
    logic        bus_gnt = 1'b0, bus_ack = 1'b0;
    logic [31:0] bus_addr, bus_wdata, bus_rdata = '0;
    logic [1:0]  bus_id;
    logic        snp_valid = 1'b0, snp_wr = 1'b0;
    logic [31:0] snp_addr = '0;
    logic [1:0]  snp_id = '0;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] mem_ovr [logic [31:0]];
    bit          m_valid [16];
    logic [25:0] m_tag   [16];

    always #2 clk = ~clk;

    wtinv_cache_ctrl #(.LOCAL_ID(MY_ID)) dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_id(bus_id),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_addr(snp_addr), .snp_id(snp_id)
    );

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        if (mem_ovr.exists(a)) return mem_ovr[a];
        return a * 32'h0000_9E37 + 32'h1234_5678;
    endfunction

    function automatic logic [31:0] mk_addr(input int tag, input int idx);
        return (32'(tag) << 6) | (32'(idx) << 2);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One processor operation; the expected hit/miss comes from the bench's line model.
    task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] wd, input int gnt_wait);
        int  idx = int'(a[5:2]);
        bit  exp_hit = !we && m_valid[idx] && (m_tag[idx] == a[31:6]);
        logic [31:0] exp_rd = mem_val(a);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        if (exp_hit) begin
            chk(cpu_done === 1'b1 && bus_req === 1'b0, "R2 hit done no bus", {30'd0, cpu_done, bus_req}, 32'h2);
            chk(cpu_rdata === exp_rd, "R2 hit data", cpu_rdata, exp_rd);
        end else begin
            chk(bus_req === 1'b1 && bus_valid === 1'b0 && cpu_done === 1'b0,
                we ? "R4 write requests bus" : "R3 miss requests bus",
                {29'd0, bus_req, bus_valid, cpu_done}, 32'h4);
            for (int k = 0; k < gnt_wait; k++) begin
                @(negedge clk);
                chk(bus_req === 1'b1 && bus_valid === 1'b0, "R5 wait for grant",
                    {30'd0, bus_req, bus_valid}, 32'h2);
            end
            bus_gnt = 1'b1;
            @(negedge clk);
            bus_gnt = 1'b0;
            chk(bus_valid === 1'b1 && bus_wr === we && bus_addr === a && bus_id === MY_ID,
                we ? "R4 bus write command" : "R3 bus read command", bus_addr, a);
            if (we) chk(bus_wdata === wd, "R4 bus write data", bus_wdata, wd);
            if (we) mem_ovr[a] = wd;
            bus_rdata = mem_val(a);
            bus_ack = 1'b1;
            @(negedge clk);
            bus_ack = 1'b0;
            chk(cpu_done === 1'b1 && bus_valid === 1'b0, "R6 done after ack",
                {30'd0, cpu_done, bus_valid}, 32'h2);
            if (!we) begin
                chk(cpu_rdata === exp_rd, "R3 fill data", cpu_rdata, exp_rd);
                m_valid[idx] = 1'b1;
                m_tag[idx] = a[31:6];
            end
        end
        @(negedge clk);
        chk(cpu_done === 1'b0 && bus_req === 1'b0, "R6 one-cycle done",
            {30'd0, cpu_done, bus_req}, 32'h0);
    endtask

    task automatic snoop(input bit wr, input logic [31:0] a, input logic [1:0] id, input logic [31:0] nv);
        int idx = int'(a[5:2]);
        @(negedge clk);
        snp_valid = 1'b1; snp_wr = wr; snp_addr = a; snp_id = id;
        @(negedge clk);
        snp_valid = 1'b0;
        if (wr && id != MY_ID) begin
            mem_ovr[a] = nv;
            if (m_valid[idx] && m_tag[idx] == a[31:6]) m_valid[idx] = 1'b0;
        end
    endtask

    function automatic bit is_hit(input logic [31:0] a);
        return m_valid[int'(a[5:2])] && (m_tag[int'(a[5:2])] == a[31:6]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        chk(cpu_done === 1'b0 && bus_req === 1'b0 && bus_valid === 1'b0, "R1 reset outputs",
            {29'd0, cpu_done, bus_req, bus_valid}, 32'h0);
        rst_n = 1'b1;

        // R1/R3: every line starts empty, so each first read misses and fills
        for (int i = 0; i < 16; i++) cpu_op(1'b0, mk_addr(0, i), '0, i % 3);
        // R2: second pass hits everywhere
        for (int i = 0; i < 16; i++) cpu_op(1'b0, mk_addr(0, i), '0, 0);
        // R4: write hits on even lines update the word, line stays valid
        for (int i = 0; i < 16; i += 2) begin
            cpu_op(1'b1, mk_addr(0, i), 32'hC0DE_0000 + 32'(i), i % 2 + 1);
            chk(is_hit(mk_addr(0, i)), "R4 hit keeps line", 32'd0, 32'd1);
            cpu_op(1'b0, mk_addr(0, i), '0, 0);
        end
        // R4/R10: write miss to another tag does not allocate; a read of it evicts
        for (int i = 1; i < 16; i += 2) begin
            cpu_op(1'b1, mk_addr(5, i), 32'hBEEF_0000 + 32'(i), 1);
            cpu_op(1'b0, mk_addr(0, i), '0, 0);  // still hits (R4 no allocate)
            cpu_op(1'b0, mk_addr(5, i), '0, 0);  // misses, R10 replaces line
            cpu_op(1'b0, mk_addr(0, i), '0, 2);  // R10 old tag now misses
        end
        // R7: foreign writes invalidate; next read fetches the new value
        for (int i = 0; i < 16; i += 3) begin
            snoop(1'b1, mk_addr(0, i), 2'd2, 32'hF00D_0000 + 32'(i));
            cpu_op(1'b0, mk_addr(0, i), '0, 1);
        end
        // R8: own-ID snoop write keeps the line
        snoop(1'b1, mk_addr(0, 1), MY_ID, '0);
        chk(is_hit(mk_addr(0, 1)), "R8 model hit", 32'd0, 32'd1);
        cpu_op(1'b0, mk_addr(0, 1), '0, 0);
        // R9: snooped read and tag-mismatched write keep the line
        snoop(1'b0, mk_addr(0, 2), 2'd3, '0);
        cpu_op(1'b0, mk_addr(0, 2), '0, 0);
        snoop(1'b1, mk_addr(9, 4), 2'd0, 32'h7777_0004);
        cpu_op(1'b0, mk_addr(0, 4), '0, 0);
        // R9/R10: the remotely written other-tag address reads its new value on a miss
        cpu_op(1'b0, mk_addr(9, 4), '0, 0);
        chk(cpu_rdata === 32'h7777_0004, "R9 remote value", cpu_rdata, 32'h7777_0004);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule